// File: doc/BRIEF.md
# Remote DMA Host Port

This block lets a host move data into and out of a local packet memory one access at a time through a single data port. The host programs a 16-bit current address and a 16-bit remaining byte count, each as two separate byte writes. Every data-port access then moves 1, 2 or 4 bytes at the current address, steps the address forward and lowers the count. When the count runs out, a completion flag is raised and stays up until the host clears it.

The memory itself lives outside the block. The block drives a 32-bit little-endian lane port with per-byte enables, and it screens every access against two legal regions. The first is a small low region, for example a station-address image. The second is the packet memory window. An access that falls outside both regions never reaches memory. A read of such an address returns all ones in its active lanes.

A programmable first and last page define a ring inside packet memory. When the address steps onto the ring's stop address, it jumps back to the ring's first page, so that a transfer can run across the end of the ring.

Top module: `rdma_host_port`

## Requirements
- R1: After reset the current address, remaining count, first page, last page and width-mode bit all read as zero, and `xfer_done` is low.
- R2: The address is written at register 1 (bits 7:0) and register 2 (upper bits). The count is written at register 3 (bits 7:0) and register 4 (bits 15:8). A write to either half leaves the other half unchanged. The live values read back at the same registers at any time.
- R3: A data-port access moves 4 bytes when `dp_long` is high. Otherwise it moves 2 bytes when bit 0 of the config register (register 7) is set, and 1 byte when that bit is clear.
- R4: After each access the address grows by the access width. If the result equals the last page (register 6) times 256, the address is reloaded with the first page (register 5) times 256.
- R5: A read, or a write with a nonzero count, lowers the count by the access width. If the count was already less than or equal to the width, it becomes zero and the done flag (status register 8, bit 6, and `xfer_done`) is set.
- R6: A data-port write while the count is zero does nothing: there is no memory write, and the address, count and done flag stay unchanged.
- R7: A write to register 0 with bit 0 (read command) or bit 1 (write command) set, while the count is zero, sets the done flag at once. With a nonzero count it has no effect on the flag.
- R8: Two- and four-byte accesses use the current address with bit 0 cleared. The byte at the lowest address travels on bits 7:0, the next byte on bits 15:8, and so on.
- R9: An access is in range when its even-forced address is below `LOW_LIMIT`, or when it lies at or above `WIN_START` and its last byte lies below `WIN_END`. An out-of-range read returns 0xFF in each active lane and zero above them. An out-of-range write asserts no `mem_we`. In both cases the address and count still advance.
- R10: The done flag stays set until a status write with bit 6 set. A status write with bit 6 clear leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write index |
| reg_wdata | input | 8 | Register write data |
| reg_raddr | input | 4 | Register read index |
| reg_rdata | output | 8 | Register read data (combinational) |
| dp_rd | input | 1 | Data-port read strobe |
| dp_wr | input | 1 | Data-port write strobe |
| dp_long | input | 1 | Selects a 4-byte access |
| dp_wdata | input | 32 | Data-port write data, lowest byte first |
| dp_rdata | output | 32 | Data-port read data, registered |
| mem_addr | output | ADDR_W | Memory byte address of lane 0 |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | 4 | Memory byte-lane enables |
| mem_wdata | output | 32 | Memory write data by lane |
| mem_rdata | input | 32 | Memory read data by lane, same cycle |
| xfer_done | output | 1 | Remote transfer complete flag |

## Verification
Register writes and data-port accesses both take effect at the single clock edge that follows the cycle in which they are presented. The bench drives stimulus on the falling edge and holds it for one cycle. At the next falling edge it reads the combinational register readback, checks the `mem_we` pulses it saw at the rising edge in between, and checks the registered `dp_rdata`, which is valid in that same cycle. The expected address, count, flag and read data come from a bench model with its own shadow of the memory. This model is advanced once per access, after the checks for that access.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

    typedef enum logic [3:0] {
        RG_CMD     = 4'h0,
        RG_ADDR_LO = 4'h1,
        RG_ADDR_HI = 4'h2,
        RG_CNT_LO  = 4'h3,
        RG_CNT_HI  = 4'h4,
        RG_FIRST   = 4'h5,
        RG_LAST    = 4'h6,
        RG_CFG     = 4'h7,
        RG_STATUS  = 4'h8
    } reg_sel_e;

    localparam int DONE_BIT   = 6;
    localparam int CMD_RD_BIT = 0;
    localparam int CMD_WR_BIT = 1;
    localparam int LANES      = 4;

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic        lng;
        logic [31:0] wdata;
    } dp_req_t;

    // number of bytes moved by one data-port access
    function automatic logic [2:0] access_bytes(input logic lng, input logic wide);
        if (lng)
            return 3'd4;
        else if (wide)
            return 3'd2;
        else
            return 3'd1;
    endfunction

endpackage

// File: rtl/rdma_cfg_regs.sv
module rdma_cfg_regs
    import rdma_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  reg_sel_e          reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        first_pg,
    output logic [7:0]        last_pg,
    output logic              wide_mode,
    output logic [ADDR_W-1:0] ring_start,
    output logic [ADDR_W-1:0] ring_stop
);

    always_ff @(posedge clk) begin
        if (rst) begin
            first_pg  <= '0;
            last_pg   <= '0;
            wide_mode <= 1'b0;
        end else if (reg_we) begin
            case (reg_sel)
                RG_FIRST: first_pg  <= reg_wdata;
                RG_LAST:  last_pg   <= reg_wdata;
                RG_CFG:   wide_mode <= reg_wdata[0];
                default: ;
            endcase
        end
    end

    assign ring_start = ADDR_W'({first_pg, 8'h00});
    assign ring_stop  = ADDR_W'({last_pg, 8'h00});

endmodule

// File: rtl/rdma_window.sv
module rdma_window
    import rdma_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LOW_LIMIT  = 32,
    parameter int WIN_START  = 16'h4000,
    parameter int WIN_END    = 16'h8000
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [2:0]        acc_bytes,
    input  logic [31:0]       dp_wdata,
    input  logic [31:0]       mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [31:0]       mem_wdata,
    output logic              in_win,
    output logic [31:0]       rd_val
);

    localparam int XW = ADDR_W + 1;
    localparam logic [XW-1:0] LOW_X   = XW'(LOW_LIMIT);
    localparam logic [XW-1:0] START_X = XW'(WIN_START);
    localparam logic [XW-1:0] END_X   = XW'(WIN_END);

    logic [XW-1:0] eaddr_x;
    logic [XW-1:0] etail_x;

    assign mem_addr = (acc_bytes == 3'd1) ? cur_addr : {cur_addr[ADDR_W-1:1], 1'b0};
    assign eaddr_x  = {1'b0, mem_addr};
    assign etail_x  = eaddr_x + XW'(acc_bytes);
    assign in_win   = (eaddr_x < LOW_X) || ((eaddr_x >= START_X) && (etail_x <= END_X));

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mem_be[i]          = (3'(i) < acc_bytes);
        assign mem_wdata[8*i +: 8] = dp_wdata[8*i +: 8];
        assign rd_val[8*i +: 8]   = !mem_be[i] ? 8'h00 :
                                    (in_win ? mem_rdata[8*i +: 8] : 8'hFF);
    end

endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
    import rdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  reg_sel_e          reg_sel,
    input  logic [7:0]        reg_wdata,
    input  logic              dp_rd,
    input  logic              dp_wr,
    input  logic [2:0]        acc_bytes,
    input  logic [ADDR_W-1:0] ring_start,
    input  logic [ADDR_W-1:0] ring_stop,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              done,
    output logic              step
);

    logic              cnt_zero;
    logic              last_beat;
    logic [CNT_W-1:0]  acc_cnt;
    logic [ADDR_W-1:0] addr_inc;
    logic [ADDR_W-1:0] addr_nxt;
    logic              cmd_zero;
    logic              done_set;
    logic              done_clr;

    assign cnt_zero  = (cur_cnt == '0);
    assign step      = dp_rd || (dp_wr && !cnt_zero);
    assign acc_cnt   = CNT_W'(acc_bytes);
    assign last_beat = (cur_cnt <= acc_cnt);
    assign addr_inc  = cur_addr + ADDR_W'(acc_bytes);
    assign addr_nxt  = (addr_inc == ring_stop) ? ring_start : addr_inc;

    assign cmd_zero = reg_we && (reg_sel == RG_CMD) && cnt_zero &&
                      (reg_wdata[CMD_RD_BIT] || reg_wdata[CMD_WR_BIT]);
    assign done_set = (step && last_beat) || cmd_zero;
    assign done_clr = reg_we && (reg_sel == RG_STATUS) && reg_wdata[DONE_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            cur_cnt  <= '0;
            done     <= 1'b0;
        end else begin
            if (step) begin
                cur_addr <= addr_nxt;
                cur_cnt  <= last_beat ? '0 : (cur_cnt - acc_cnt);
            end
            if (reg_we) begin
                case (reg_sel)
                    RG_ADDR_LO: cur_addr[7:0]        <= reg_wdata;
                    RG_ADDR_HI: cur_addr[ADDR_W-1:8] <= reg_wdata[ADDR_W-9:0];
                    RG_CNT_LO:  cur_cnt[7:0]         <= reg_wdata;
                    RG_CNT_HI:  cur_cnt[CNT_W-1:8]   <= reg_wdata[CNT_W-9:0];
                    default: ;
                endcase
            end
            done <= done_set || (done && !done_clr);
        end
    end

endmodule

// File: rtl/rdma_host_port.sv
module rdma_host_port
    import rdma_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int LOW_LIMIT = 32,
    parameter int WIN_START = 16'h4000,
    parameter int WIN_END   = 16'h8000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [3:0]        reg_waddr,
    input  logic [7:0]        reg_wdata,
    input  logic [3:0]        reg_raddr,
    output logic [7:0]        reg_rdata,
    input  logic              dp_rd,
    input  logic              dp_wr,
    input  logic              dp_long,
    input  logic [31:0]       dp_wdata,
    output logic [31:0]       dp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              xfer_done
);

    localparam int CNT_W = 16;

    dp_req_t           req;
    reg_sel_e          wsel;
    reg_sel_e          rsel;
    logic [7:0]        first_pg;
    logic [7:0]        last_pg;
    logic              wide_mode;
    logic [ADDR_W-1:0] ring_start;
    logic [ADDR_W-1:0] ring_stop;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  cur_cnt;
    logic              step;
    logic [2:0]        acc_bytes;
    logic              in_win;
    logic [31:0]       rd_val;
    logic [31:0]       rdata_q;
    logic [15:0]       addr_ext;

    assign req  = '{rd: dp_rd, wr: dp_wr && !dp_rd, lng: dp_long, wdata: dp_wdata};
    assign wsel = reg_sel_e'(reg_waddr);
    assign rsel = reg_sel_e'(reg_raddr);
    assign acc_bytes = access_bytes(req.lng, wide_mode);

    rdma_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_sel    (wsel),
        .reg_wdata  (reg_wdata),
        .first_pg   (first_pg),
        .last_pg    (last_pg),
        .wide_mode  (wide_mode),
        .ring_start (ring_start),
        .ring_stop  (ring_stop)
    );

    rdma_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_sel    (wsel),
        .reg_wdata  (reg_wdata),
        .dp_rd      (req.rd),
        .dp_wr      (req.wr),
        .acc_bytes  (acc_bytes),
        .ring_start (ring_start),
        .ring_stop  (ring_stop),
        .cur_addr   (cur_addr),
        .cur_cnt    (cur_cnt),
        .done       (xfer_done),
        .step       (step)
    );

    rdma_window #(
        .ADDR_W    (ADDR_W),
        .LOW_LIMIT (LOW_LIMIT),
        .WIN_START (WIN_START),
        .WIN_END   (WIN_END)
    ) u_win (
        .cur_addr  (cur_addr),
        .acc_bytes (acc_bytes),
        .dp_wdata  (req.wdata),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .in_win    (in_win),
        .rd_val    (rd_val)
    );

    assign mem_we = step && req.wr && in_win;

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (req.rd)
            rdata_q <= rd_val;
    end
    assign dp_rdata = rdata_q;

    assign addr_ext = 16'(cur_addr);

    always_comb begin
        case (rsel)
            RG_ADDR_LO: reg_rdata = addr_ext[7:0];
            RG_ADDR_HI: reg_rdata = addr_ext[15:8];
            RG_CNT_LO:  reg_rdata = cur_cnt[7:0];
            RG_CNT_HI:  reg_rdata = cur_cnt[15:8];
            RG_FIRST:   reg_rdata = first_pg;
            RG_LAST:    reg_rdata = last_pg;
            RG_CFG:     reg_rdata = {7'd0, wide_mode};
            RG_STATUS:  reg_rdata = 8'(xfer_done) << DONE_BIT;
            default:    reg_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/rdma_host_port_chk.sv
module rdma_host_port_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [3:0]        reg_waddr,
    input logic [7:0]        reg_wdata,
    input logic              dp_rd,
    input logic              dp_wr,
    input logic              mem_we,
    input logic [3:0]        mem_be,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              xfer_done,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [15:0]       cur_cnt,
    input logic [2:0]        acc_bytes,
    input logic [ADDR_W-1:0] ring_stop
);

    logic accessing;
    assign accessing = dp_rd || (dp_wr && cur_cnt != 16'd0);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (accessing && !reg_we && cur_cnt > 16'(acc_bytes))
        |=> cur_cnt == $past(cur_cnt) - 16'($past(acc_bytes))); // R5

    AST_DONE_FINAL: assert property (@(posedge clk) disable iff (rst)
        (accessing && cur_cnt <= 16'(acc_bytes)) |=> xfer_done); // R5

    AST_EMPTY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (dp_wr && !dp_rd && cur_cnt == 16'd0) |-> !mem_we); // R6

    AST_EVEN_WIDE: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_be != 4'b0001) |-> !mem_addr[0]); // R8

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (accessing && !reg_we && (cur_addr + ADDR_W'(acc_bytes)) != ring_stop)
        |=> cur_addr == $past(cur_addr) + ADDR_W'($past(acc_bytes))); // R4

    AST_ZERO_CMD: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_waddr == 4'h0 && reg_wdata[1:0] != 2'b00 && cur_cnt == 16'd0)
        |=> xfer_done); // R7

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && !(reg_we && reg_waddr == 4'h8 && reg_wdata[6])) |=> xfer_done); // R10

endmodule

bind rdma_host_port rdma_host_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_waddr (reg_waddr),
    .reg_wdata (reg_wdata),
    .dp_rd     (dp_rd),
    .dp_wr     (dp_wr),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .mem_addr  (mem_addr),
    .xfer_done (xfer_done),
    .cur_addr  (cur_addr),
    .cur_cnt   (cur_cnt),
    .acc_bytes (acc_bytes),
    .ring_stop (ring_stop)
);

// File: tb/sim_rdma_host_port.sv
module sim_rdma_host_port;

    localparam int CLK_PERIOD = 10;
    localparam int MSZ        = 512;
    localparam int LOWL       = 32;
    localparam int WSTART     = 16'h0100;
    localparam int WEND       = 16'h0200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_waddr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [3:0]  reg_raddr = '0;
    logic [7:0]  reg_rdata;
    logic        dp_rd = 1'b0;
    logic        dp_wr = 1'b0;
    logic        dp_long = 1'b0;
    logic [31:0] dp_wdata = '0;
    logic [31:0] dp_rdata;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        xfer_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    rdma_host_port #(
        .ADDR_W(16), .LOW_LIMIT(LOWL), .WIN_START(WSTART), .WIN_END(WEND)
    ) u0 (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .dp_rd(dp_rd), .dp_wr(dp_wr), .dp_long(dp_long),
        .dp_wdata(dp_wdata), .dp_rdata(dp_rdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .xfer_done(xfer_done)
    );

    // external memory driven by the design, and an independent shadow
    logic [7:0] bmem   [MSZ];
    logic [7:0] shadow [MSZ];
    int we_cnt = 0;

    always_comb begin
        for (int i = 0; i < 4; i++)
            mem_rdata[8*i +: 8] = bmem[(int'(mem_addr) + i) % MSZ];
    end

    always @(posedge clk) begin
        if (mem_we) begin
            we_cnt <= we_cnt + 1;
            for (int i = 0; i < 4; i++)
                if (mem_be[i]) bmem[(int'(mem_addr) + i) % MSZ] <= mem_wdata[8*i +: 8];
        end
    end

    // bench model state
    logic [15:0] m_addr;
    logic [15:0] m_cnt;
    logic        m_done;
    logic        m_cfg;
    logic [7:0]  m_first;
    logic [7:0]  m_last;

    int n_chk = 0;
    int n_fail = 0;
    bit over = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!over) begin
            over = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        case (a)
            4'h0: if (d[1:0] != 2'b00 && m_cnt == 16'd0) m_done = 1'b1;
            4'h1: m_addr[7:0]  = d;
            4'h2: m_addr[15:8] = d;
            4'h3: m_cnt[7:0]   = d;
            4'h4: m_cnt[15:8]  = d;
            4'h5: m_first = d;
            4'h6: m_last  = d;
            4'h7: m_cfg   = d[0];
            4'h8: if (d[6]) m_done = 1'b0;
            default: ;
        endcase
    endtask

    task automatic set_addr(input logic [15:0] a);
        wr_reg(4'h1, a[7:0]);
        wr_reg(4'h2, a[15:8]);
    endtask

    task automatic set_cnt(input logic [15:0] c);
        wr_reg(4'h3, c[7:0]);
        wr_reg(4'h4, c[15:8]);
    endtask

    task automatic check_state(input string ra, input string rc);
        logic [7:0] lo, hi, st;
        rd_reg(4'h1, lo); rd_reg(4'h2, hi);
        chk(ra, {16'd0, hi, lo}, {16'd0, m_addr});
        rd_reg(4'h3, lo); rd_reg(4'h4, hi);
        chk(rc, {16'd0, hi, lo}, {16'd0, m_cnt});
        rd_reg(4'h8, st);
        chk(rc, {24'd0, st}, {24'd0, 1'b0, m_done, 6'd0});
        chk(rc, {31'd0, xfer_done}, {31'd0, m_done});
    endtask

    function automatic bit in_window(input logic [15:0] e, input int w);
        return (int'(e) < LOWL) || (int'(e) >= WSTART && int'(e) + w <= WEND);
    endfunction

    function automatic logic [31:0] exp_read(input logic [15:0] e, input int w);
        logic [31:0] v = '0;
        bit win = in_window(e, w);
        for (int i = 0; i < w; i++)
            v[8*i +: 8] = win ? shadow[(int'(e) + i) % MSZ] : 8'hFF;
        return v;
    endfunction

    // one data-port access, checked and then applied to the model
    task automatic access(input bit rd, input bit lng, input logic [31:0] wd, input string rtag);
        int w = lng ? 4 : (m_cfg ? 2 : 1);
        logic [15:0] e = (w == 1) ? m_addr : {m_addr[15:1], 1'b0};
        bit win = in_window(e, w);
        bit doit = rd || (m_cnt != 16'd0);
        int we0 = we_cnt;
        logic [31:0] er = exp_read(e, w);
        logic [15:0] stop_a = {m_last, 8'h00};
        @(negedge clk);
        dp_rd = rd; dp_wr = !rd; dp_long = lng; dp_wdata = wd;
        @(negedge clk);
        dp_rd = 1'b0; dp_wr = 1'b0; dp_long = 1'b0;
        if (rd) chk(rtag, dp_rdata, er);
        else    chk(doit ? "R9" : "R6", 32'(we_cnt - we0), (doit && win) ? 32'd1 : 32'd0);
        if (doit) begin
            if (!rd && win)
                for (int i = 0; i < w; i++) shadow[(int'(e) + i) % MSZ] = wd[8*i +: 8];
            m_addr = m_addr + 16'(w);
            if (m_addr == stop_a) m_addr = {m_first, 8'h00};
            if (m_cnt <= 16'(w)) begin
                m_cnt = 16'd0;
                m_done = 1'b1;
            end else begin
                m_cnt = m_cnt - 16'(w);
            end
        end
        check_state(doit ? "R4" : "R6", doit ? "R5" : "R6");
    endtask

    initial begin
        logic [7:0] d;
        void'($urandom(32'd20240611));
        for (int i = 0; i < MSZ; i++) begin
            bmem[i]   = 8'((i * 7 + 3) & 255);
            shadow[i] = 8'((i * 7 + 3) & 255);
        end
        m_addr = '0; m_cnt = '0; m_done = 1'b0; m_cfg = 1'b0; m_first = '0; m_last = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check_state("R1", "R1");
        rd_reg(4'h5, d); chk("R1", {24'd0, d}, 32'd0);
        rd_reg(4'h6, d); chk("R1", {24'd0, d}, 32'd0);
        rd_reg(4'h7, d); chk("R1", {24'd0, d}, 32'd0);

        // R2 half writes
        set_addr(16'h1234);
        wr_reg(4'h1, 8'h56);
        check_state("R2", "R2");
        set_cnt(16'hA5C3);
        wr_reg(4'h4, 8'h01);
        check_state("R2", "R2");

        // ring setup for the rest
        wr_reg(4'h5, 8'h01);
        wr_reg(4'h6, 8'h02);

        // R7 zero-length command, R10 sticky flag
        set_cnt(16'd0);
        wr_reg(4'h0, 8'h01);
        check_state("R7", "R7");
        wr_reg(4'h8, 8'h00);
        check_state("R10", "R10");
        chk("R10", {31'd0, xfer_done}, 32'd1);
        wr_reg(4'h8, 8'h40);
        chk("R10", {31'd0, xfer_done}, 32'd0);
        set_cnt(16'd5);
        wr_reg(4'h0, 8'h02);
        chk("R7", {31'd0, xfer_done}, 32'd0);

        // R3 byte mode writes and read back
        set_addr(16'h0110);
        set_cnt(16'd3);
        access(0, 0, 32'h0000_00AA, "R3");
        access(0, 0, 32'h0000_00BB, "R3");
        access(0, 0, 32'h0000_00CC, "R3");
        chk("R3", {24'd0, bmem[16'h111]}, 32'h0000_00BB);
        wr_reg(4'h8, 8'h40);

        // R8 word mode at odd address forces even, little-endian lanes
        wr_reg(4'h7, 8'h01);
        set_addr(16'h0121);
        set_cnt(16'd2);
        access(0, 0, 32'h0000_BEEF, "R8");
        chk("R8", {24'd0, bmem[16'h120]}, 32'h0000_00EF);
        chk("R8", {24'd0, bmem[16'h121]}, 32'h0000_00BE);
        set_addr(16'h0120);
        set_cnt(16'd6);
        access(1, 0, 32'd0, "R8");
        access(0, 1, 32'h4433_2211, "R3");
        set_addr(16'h0122);
        access(1, 1, 32'd0, "R3");
        wr_reg(4'h8, 8'h40);

        // R4 wrap at stop page
        set_addr(16'h01FE);
        set_cnt(16'd10);
        access(1, 0, 32'd0, "R4");
        chk("R4", {16'd0, m_addr}, 32'h0000_0100);

        // R9 out-of-window accesses
        set_addr(16'h0080);
        access(1, 0, 32'd0, "R9");
        access(1, 1, 32'd0, "R9");
        access(0, 0, 32'h0000_1234, "R9");
        wr_reg(4'h7, 8'h00);
        access(1, 0, 32'd0, "R9");

        // R6 writes ignored at zero count
        set_cnt(16'd0);
        set_addr(16'h0130);
        access(0, 0, 32'h0000_0077, "R6");
        access(0, 1, 32'h7777_7777, "R6");

        // random mix
        for (int it = 0; it < 400; it++) begin
            int sel = int'($urandom_range(0, 9));
            if (sel == 0) begin
                logic [15:0] a;
                case ($urandom_range(0, 4))
                    0: a = 16'($urandom_range(0, 31));
                    1: a = 16'($urandom_range(32'h100, 32'h1FF));
                    2: a = 16'($urandom_range(32'h1F8, 32'h1FF));
                    3: a = 16'($urandom_range(32'h20, 32'hFF));
                    default: a = 16'($urandom_range(32'h200, 32'h2FF));
                endcase
                set_addr(a);
                set_cnt(16'($urandom_range(0, 12)));
            end else if (sel == 1) begin
                wr_reg(4'h7, 8'($urandom_range(0, 1)));
            end else if (sel == 2) begin
                wr_reg(4'h8, 8'h40);
            end else begin
                access(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 3) == 0),
                       $urandom, "R3");
            end
        end

        finish_run();
    end

endmodule